// File: doc/BRIEF.md
# Receive Cell Parity and Framing Checker

This block sits on a byte-wide receive path that carries fixed-length cells. It checks the odd parity of every accepted byte against a parity bit supplied with that byte. It also checks that the start-of-cell marker appears on the first byte of every cell and on no other byte.

A cell is sent downstream only once all of its bytes have arrived with correct framing. The cell goes out as a burst of consecutive valid bytes, and the first byte of the burst is marked. The two kinds of error are handled differently. A parity mismatch raises a one-cycle pulse, and the cell is still forwarded and counted. A framing fault raises its own one-cycle pulse, and the cell it affects is discarded. After a framing fault the block drops bytes until a start marker arrives, then counts from there. A wrapping counter records how many cells were forwarded.

Cells are held in two cell-sized banks. One bank fills while the other drains, so back-to-back cells at one byte per clock flow through without loss.

Top module: `utopia_rx_check`

## Requirements
- R1: One cycle after a byte is accepted (`in_valid` high), `par_err` is high for exactly that cycle if the 8 data bits and `in_par` together hold an even number of ones. Otherwise it is low.
- R2: A cell that contains parity-errored bytes is still forwarded unchanged and still counted.
- R3: A byte with `in_soc` high at position 1 to CELL_LEN-1 of a cell in progress causes a `frm_err` pulse in the next cycle. The partial cell is discarded, and that byte becomes position 0 of a new cell.
- R4: When a cell has completed and the next accepted byte lacks `in_soc`, `frm_err` pulses in the next cycle. Bytes are then dropped without further framing errors until a byte with `in_soc` arrives.
- R5: After reset the block waits for a start marker. Bytes without `in_soc` are dropped, raise no `frm_err` and are not counted.
- R6: A complete cell appears on `out_data` as CELL_LEN consecutive cycles of `out_valid`, in arrival order. The burst starts two cycles after its last byte is presented, and `out_soc` is high only on the first byte.
- R7: `cell_count` is CNT_W bits wide (16 by default). It increments by one at the clock edge that accepts the last byte of a forwarded cell, and it wraps to zero after its maximum value.
- R8: While reset is active and after reset, `out_valid`, `out_soc`, `par_err`, `frm_err` and `cell_count` are zero.
- R9: Cycles with `in_valid` low have no effect, whatever `in_data`, `in_soc` and `in_par` carry. Gaps inside a cell are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | DATA_W | Input byte |
| in_par | input | 1 | Odd parity bit for in_data |
| in_soc | input | 1 | Start-of-cell marker for the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DATA_W | Forwarded byte |
| out_soc | output | 1 | Marks the first byte of a forwarded cell |
| par_err | output | 1 | One-cycle parity mismatch pulse |
| frm_err | output | 1 | One-cycle framing fault pulse |
| cell_count | output | CNT_W | Count of forwarded cells, wrapping |

## Verification
The bench builds the block with CELL_LEN = 4 and CNT_W = 4. Short cells let misplaced markers, missing markers, mid-cell gaps and back-to-back bursts all be tried within a few hundred cycles. The 4-bit counter wraps after sixteen cells, so the rollover in R7 is reached without sending 65536 cells. The bank hand-over, where one cell finishes draining on the same edge the next one completes, is exercised with cells sent with no idle cycles between them.

// File: rtl/utopia_rx_check.sv
module utopia_rx_check #(
  parameter int DATA_W   = 8,
  parameter int CELL_LEN = 53,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_par,
  input  logic              in_soc,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_soc,
  output logic              par_err,
  output logic              frm_err,
  output logic [CNT_W-1:0]  cell_count
);
  localparam int IW    = $clog2(CELL_LEN);
  localparam int DEPTH = 2 * CELL_LEN;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [IW-1:0] LAST = IW'(CELL_LEN - 1);

  logic              hunt, wbank, rbank, ractive;
  logic [IW-1:0]     widx, ridx;
  logic [DATA_W-1:0] mem [DEPTH];

  logic          par_bad, mid_soc, miss_soc, accept, done;
  logic [IW-1:0] wpos;
  logic [AW-1:0] waddr, raddr;

  assign par_bad  = in_valid && !(^{in_data, in_par});
  assign mid_soc  = in_valid && in_soc && !hunt && (widx != '0);
  assign miss_soc = in_valid && !in_soc && !hunt && (widx == '0);
  assign accept   = in_valid && (in_soc || (!hunt && (widx != '0)));
  assign wpos     = in_soc ? '0 : widx;
  assign done     = accept && (wpos == LAST);
  assign waddr    = AW'(wpos) + (wbank ? AW'(CELL_LEN) : '0);
  assign raddr    = AW'(ridx) + (rbank ? AW'(CELL_LEN) : '0);

  always_ff @(posedge clk)
    if (accept) mem[waddr] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hunt    <= 1'b1;
      widx    <= '0;
      wbank   <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      par_err <= par_bad;
      frm_err <= mid_soc || miss_soc;
      if (accept) begin
        hunt <= 1'b0;
        widx <= done ? '0 : wpos + 1'b1;
        if (done) wbank <= ~wbank;
      end else if (miss_soc) begin
        hunt <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ractive    <= 1'b0;
      ridx       <= '0;
      rbank      <= 1'b0;
      out_valid  <= 1'b0;
      out_soc    <= 1'b0;
      out_data   <= '0;
      cell_count <= '0;
    end else begin
      out_valid <= ractive;
      out_soc   <= ractive && (ridx == '0);
      if (ractive) begin
        out_data <= mem[raddr];
        ridx     <= (ridx == LAST) ? '0 : ridx + 1'b1;
        if (ridx == LAST) ractive <= 1'b0;
      end
      if (done) begin
        ractive    <= 1'b1;
        ridx       <= '0;
        rbank      <= wbank;
        cell_count <= cell_count + 1'b1;
      end
    end
  end

  // R6
  burst_starts_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_soc);
  // R6
  marker_inside_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> out_valid);
  // R7
  count_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_count != $past(cell_count)) |-> (cell_count == CNT_W'($past(cell_count) + 1'b1)));
  // R7
  count_then_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_count != $past(cell_count)) |=> out_soc);
  // R1
  parity_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(in_valid));
  // R3
  framing_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |-> $past(in_valid));
endmodule

// File: tb/utopia_rx_check_test.sv
module utopia_rx_check_test;
  localparam int CL = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_par = 1'b0;
  logic          in_soc = 1'b0;
  logic          out_valid, out_soc, par_err, frm_err;
  logic [7:0]    out_data;
  logic [CW-1:0] cell_count;

  int            checks = 0;
  int            errors = 0;
  logic [CW-1:0] exp_cnt = '0;
  logic [8:0]    expq[$];

  always #10 clk = ~clk;

  utopia_rx_check #(.DATA_W(8), .CELL_LEN(CL), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_par(in_par), .in_soc(in_soc), .out_valid(out_valid), .out_data(out_data),
    .out_soc(out_soc), .par_err(par_err), .frm_err(frm_err), .cell_count(cell_count));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b0; in_soc = 1'b1; in_data = 8'hFF; in_par = 1'b0;
      @(negedge clk);
      check(!par_err && !frm_err, "R9 idle pulses", {par_err, frm_err}, 0);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic soc, input logic badp,
                           input logic expf, input string req);
    in_valid = 1'b1; in_data = d; in_soc = soc;
    in_par = badp ? ^d : ~^d;
    @(negedge clk);
    in_valid = 1'b0;
    check(par_err == badp, {"R1 par_err ", req}, par_err, badp);
    check(frm_err == expf, {"framing pulse ", req}, frm_err, expf);
  endtask

  task automatic send_cell(input logic [7:0] base, input int badpos, input bit gap,
                           input string req);
    for (int i = 0; i < CL; i++) expq.push_back({i == 0, 8'(base + i)});
    for (int i = 0; i < CL; i++) begin
      send_byte(8'(base + i), i == 0, i == badpos, 1'b0, req);
      if (gap && i != CL - 1) idle(1);
    end
    exp_cnt = exp_cnt + 1'b1;
    check(cell_count == exp_cnt, {"R7 count ", req}, cell_count, exp_cnt);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3/R4 unexpected output byte actual=%0h expected=none", out_data);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        check({out_soc, out_data} == e, "R6 output byte", {out_soc, out_data}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !out_soc && !par_err && !frm_err && cell_count == 0,
          "R8 in reset", {out_valid, out_soc, par_err, frm_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && cell_count == 0, "R8 after reset", cell_count, 0);

    send_byte(8'h11, 1'b0, 1'b0, 1'b0, "R5 hunt");
    send_byte(8'h12, 1'b0, 1'b1, 1'b0, "R5 hunt bad parity");
    idle(2);
    check(cell_count == 0, "R5 no count", cell_count, 0);

    send_cell(8'h20, -1, 1'b0, "R6 clean");
    idle(3);
    send_cell(8'h30, 2, 1'b0, "R2 parity cell");
    send_cell(8'hFE, 0, 1'b0, "R2 parity on first byte");
    send_cell(8'h40, -1, 1'b0, "R6 back-to-back a");
    send_cell(8'h50, -1, 1'b0, "R6 back-to-back b");
    send_cell(8'h60, -1, 1'b1, "R9 gapped");
    idle(2);

    send_byte(8'h70, 1'b1, 1'b0, 1'b0, "R3 start");
    send_byte(8'h71, 1'b0, 1'b0, 1'b0, "R3 body");
    for (int i = 0; i < CL; i++) expq.push_back({i == 0, 8'(8'h80 + i)});
    send_byte(8'h80, 1'b1, 1'b0, 1'b1, "R3 misplaced marker");
    for (int i = 1; i < CL; i++) send_byte(8'(8'h80 + i), 1'b0, 1'b0, 1'b0, "R3 new cell");
    exp_cnt = exp_cnt + 1'b1;
    check(cell_count == exp_cnt, "R3 restarted cell counted", cell_count, exp_cnt);
    idle(2);

    send_byte(8'h90, 1'b0, 1'b0, 1'b1, "R4 missing marker");
    send_byte(8'h91, 1'b0, 1'b0, 1'b0, "R4 discard quiet");
    send_byte(8'h92, 1'b0, 1'b1, 1'b0, "R4 discard parity");
    check(cell_count == exp_cnt, "R4 dropped not counted", cell_count, exp_cnt);
    send_cell(8'hA0, -1, 1'b0, "R4 resync");

    for (int c = 0; c < 10; c++) send_cell(8'(8'hB0 + 4 * c), -1, 1'b0, "R7 wrap");
    check(cell_count == 4'd2, "R7 wrapped value", cell_count, 2);

    idle(2 * CL + 4);
    check(expq.size() == 0, "R6 all bytes delivered", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule